// File: doc/BRIEF.md
# Nested-Ring Priority Address-Bus Arbiter

This block decides which of N bus masters may start the next address tenure. Every master presents a request line, a 2-bit priority level and a repeat attribute. The arbiter answers with a registered one-hot grant. It keeps that grant until the granted master signals the end of its tenure with a one-cycle done pulse. The arbiter then makes its next decision in the following cycle.

Levels are not strict priority. Each level runs a round-robin ring over its own requesters. Every level above 0 also has one extra placeholder slot in its ring. When the placeholder's turn comes, the decision is handed down to the next lower level that has a requester. Because of this, lower levels always receive a fixed share of the bandwidth. A lone master at the top level gets one grant in two. Two masters one level down each get one grant in six, provided a third level below them is also requesting.

A master may move between levels at any time. The arbiter uses the level presented in the cycle it decides. The repeat attribute of the winning master is captured with the grant and shown on a status output. It has no effect on the grant order.

Top module: `prio_ring_arbiter`

## Requirements
- R1: While reset is held, and after it is released until the first request, no grant is asserted. Every level's ring pointer restarts at ring position 0, so the first grant on a level goes to its lowest-indexed requester.
- R2: `grant_o` has at most one bit set. A grant that appears in a cycle goes only to a master whose `req_i` bit was high in the cycle before.
- R3: The decision starts at the highest level that has a requester. Level L of master i is `prio_i[2*i+1:2*i]`, where 0 is the lowest level and 3 the highest.
- R4: Within one level, requesters are served in cyclic order of master index. The search starts just after the last master granted at that level.
- R5: Each level above 0 has a placeholder at ring position N, after the last master index. When the placeholder's turn comes, that level's pointer returns to position 0 and the decision moves down to the next lower level that has a requester.
- R6: A placeholder is passed over when no lower level has a requester. Levels without requesters are skipped. Whenever any request is present, a grant is issued.
- R7: With one master at level 3, two at level 2 and one at level 1, all requesting continuously, the level-3 master gets every second grant. The level-2 masters each get one grant in six.
- R8: A change of a master's level takes effect at the next decision.
- R9: A grant appears one cycle after the decision cycle in which a request is present. It holds until `tenure_done_i` is high. It clears at that clock edge. The next decision happens one cycle later.
- R10: `grant_rpt_o` shows the `rpt_i` bit of the granted master, captured at the decision. It is 0 while no grant is asserted.
- R11: With no request present, no grant appears, and a `tenure_done_i` pulse while no grant is asserted has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | N | Bus request, one bit per master |
| prio_i | input | 2*N | Priority level, 2 bits per master, master i at bits 2i+1:2i |
| rpt_i | input | N | Repeat attribute, one bit per master |
| tenure_done_i | input | 1 | One-cycle pulse ending the current address tenure |
| grant_o | output | N | Registered one-hot bus grant |
| grant_rpt_o | output | 1 | Repeat attribute of the granted master |

## Verification
A grant is due one clock after the edge that sees the request in the idle state. It clears on the edge that sees `tenure_done_i`. After that, the next grant is due two clocks after the done pulse was raised. The bench drives inputs and samples outputs only on falling edges. After each done pulse it checks for an empty grant at the next falling edge. The monitor compares each newly raised grant, together with its repeat status, against the next entry of the expected-order queue. Hold behaviour and the single-cycle grant latency are checked on consecutive falling edges after the request is raised.

// File: rtl/prio_ring_pkg.sv
// Package: shared constants and types for the nested-ring arbiter.
// Assumes the level field is 2 bits wide, which gives four levels.
package prio_ring_pkg;
    localparam int LEVELS = 4;
    localparam int PRIO_W = 2;
    typedef logic [PRIO_W-1:0] prio_t;
endpackage

// File: rtl/prio_level_decode.sv
// prio_level_decode: sorts the request vector into one member mask per level.
// It also flags, for each level, whether any lower level has a requester.
// Assumes prio_flat packs master i's level at bits 2i+1:2i.
module prio_level_decode
    import prio_ring_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N-1:0]                req,
    input  logic [N*PRIO_W-1:0]         prio_flat,
    output logic [LEVELS-1:0][N-1:0]    member,
    output logic [LEVELS-1:0]           lvl_any,
    output logic [LEVELS-1:0]           lower_any
);
    // Member mask: requesting masters whose presented level matches.
    always_comb begin
        for (int l = 0; l < LEVELS; l++) begin
            for (int i = 0; i < N; i++) begin
                member[l][i] = req[i] && (prio_t'(prio_flat[i*PRIO_W +: PRIO_W]) == prio_t'(l));
            end
        end
    end

    genvar gl;
    generate
        for (gl = 0; gl < LEVELS; gl++) begin : g_lvl
            assign lvl_any[gl] = |member[gl];
            if (gl == 0) begin : g_bottom
                assign lower_any[gl] = 1'b0;
            end else begin : g_upper
                assign lower_any[gl] = |lvl_any[gl-1:0];
            end
        end
    endgenerate
endmodule

// File: rtl/prio_ring_pick.sv
// prio_ring_pick: round-robin search over one level's ring of N+1 positions.
// Positions 0..N-1 are masters and position N is the placeholder.
// The search starts at ptr and returns the first eligible position.
// Assumes ptr <= N.
module prio_ring_pick #(
    parameter int N  = 8,
    parameter int PW = $clog2(N + 1)
) (
    input  logic [N-1:0]  member,
    input  logic          ph_en,
    input  logic [PW-1:0] ptr,
    output logic          found,
    output logic          is_ph,
    output logic [PW-1:0] pos
);
    logic [N:0] cand;
    assign cand = {ph_en, member};

    // Cyclic first-eligible search beginning at the pointer.
    always_comb begin
        logic [PW:0] slot;
        found = 1'b0;
        is_ph = 1'b0;
        pos   = '0;
        for (int k = 0; k <= N; k++) begin
            slot = {1'b0, ptr} + (PW+1)'(k);
            if (slot > (PW+1)'(N)) begin
                slot = slot - (PW+1)'(N + 1);
            end
            if (!found && cand[slot[PW-1:0]]) begin
                found = 1'b1;
                pos   = slot[PW-1:0];
                is_ph = (slot == (PW+1)'(N));
            end
        end
    end
endmodule

// File: rtl/prio_ring_arbiter.sv
// prio_ring_arbiter: address-bus arbiter built from nested round-robin rings.
// The top non-empty level decides first. A placeholder win passes the
// decision down to lower levels. The grant is registered and held until
// tenure_done_i. Assumes requests stay stable while a grant is pending.
module prio_ring_arbiter
    import prio_ring_pkg::*;
#(
    parameter int N = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N-1:0]        req_i,
    input  logic [N*PRIO_W-1:0] prio_i,
    input  logic [N-1:0]        rpt_i,
    input  logic                tenure_done_i,
    output logic [N-1:0]        grant_o,
    output logic                grant_rpt_o
);
    localparam int PW = $clog2(N + 1);

    logic [LEVELS-1:0][N-1:0]  member;
    logic [LEVELS-1:0]         lvl_any;
    logic [LEVELS-1:0]         lower_any;
    logic [LEVELS-1:0][PW-1:0] ptr_q, ptr_d;
    logic [LEVELS-1:0]         pk_found, pk_ph;
    logic [LEVELS-1:0][PW-1:0] pk_pos;
    logic [N-1:0]              win_oh;
    logic                      win_any;
    logic                      busy_q;

    prio_level_decode #(.N(N)) u_decode (
        .req       (req_i),
        .prio_flat (prio_i),
        .member    (member),
        .lvl_any   (lvl_any),
        .lower_any (lower_any)
    );

    genvar gl;
    generate
        for (gl = 0; gl < LEVELS; gl++) begin : g_ring
            prio_ring_pick #(.N(N), .PW(PW)) u_pick (
                .member (member[gl]),
                .ph_en  (lower_any[gl]),
                .ptr    (ptr_q[gl]),
                .found  (pk_found[gl]),
                .is_ph  (pk_ph[gl]),
                .pos    (pk_pos[gl])
            );
        end
    endgenerate

    // Walk the levels top-down: placeholder wins fall through, a member win stops.
    always_comb begin
        win_oh  = '0;
        win_any = 1'b0;
        ptr_d   = ptr_q;
        for (int l = LEVELS - 1; l >= 0; l--) begin
            if (!win_any && lvl_any[l] && pk_found[l]) begin
                if (pk_ph[l]) begin
                    ptr_d[l] = '0;
                end else begin
                    for (int i = 0; i < N; i++) begin
                        if (pk_pos[l] == PW'(i)) begin
                            win_oh[i] = 1'b1;
                        end
                    end
                    ptr_d[l] = pk_pos[l] + PW'(1);
                    win_any  = 1'b1;
                end
            end
        end
    end

    // Grant register, tenure handshake and ring pointer update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_o     <= '0;
            grant_rpt_o <= 1'b0;
            busy_q      <= 1'b0;
            ptr_q       <= '0;
        end else if (busy_q) begin
            if (tenure_done_i) begin
                grant_o     <= '0;
                grant_rpt_o <= 1'b0;
                busy_q      <= 1'b0;
            end
        end else if (win_any) begin
            grant_o     <= win_oh;
            grant_rpt_o <= |(win_oh & rpt_i);
            busy_q      <= 1'b1;
            ptr_q       <= ptr_d;
        end
    end
endmodule

// File: rtl/prio_ring_arbiter_chk.sv
// prio_ring_arbiter_chk: port-level properties of the arbiter, bound to the top.
// Assumes a synchronous active-low reset.
module prio_ring_arbiter_chk #(
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [N-1:0] req_i,
    input logic         tenure_done_i,
    input logic [N-1:0] grant_o,
    input logic         grant_rpt_o
);
    // R2: at most one master holds the grant.
    a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o));

    // R2: a new grant goes only to a master that was requesting.
    a_r2_to_requester: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o == '0) |=> ((grant_o & ~$past(req_i)) == '0));

    // R9: the grant is held while the tenure is running.
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o != '0 && !tenure_done_i) |=> (grant_o == $past(grant_o)));

    // R9: a done pulse releases the grant.
    a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o != '0 && tenure_done_i) |=> (grant_o == '0));

    // R6: an idle arbiter with a request always grants.
    a_r6_no_idle_loss: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o == '0 && req_i != '0) |=> (grant_o != '0));

    // R11: no request, no grant.
    a_r11_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o == '0 && req_i == '0) |=> (grant_o == '0));

    // R10: the repeat status is only shown with a grant.
    a_r10_rpt_with_grant: assert property (@(posedge clk) disable iff (!rst_n)
        grant_rpt_o |-> (grant_o != '0));
endmodule

bind prio_ring_arbiter prio_ring_arbiter_chk #(.N(N)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_i         (req_i),
    .tenure_done_i (tenure_done_i),
    .grant_o       (grant_o),
    .grant_rpt_o   (grant_rpt_o)
);

// File: tb/prio_ring_arbiter_tb_top.sv
// prio_ring_arbiter_tb_top: scoreboard bench. The driver queues the expected
// grant order and the monitor checks each newly raised grant against it.
module prio_ring_arbiter_tb_top;
    localparam int N = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N-1:0]   req = '0;
    logic [2*N-1:0] prio = '0;
    logic [N-1:0]   rpt = '0;
    logic           done = 1'b0;
    logic [N-1:0]   grant;
    logic           grant_rpt;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  finished = 1'b0;
    int  exp_idx[$];
    bit  exp_rpt[$];
    logic [N-1:0] prev_grant = '0;

    always #2.5 clk = ~clk;

    prio_ring_arbiter #(.N(N)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_i         (req),
        .prio_i        (prio),
        .rpt_i         (rpt),
        .tenure_done_i (done),
        .grant_o       (grant),
        .grant_rpt_o   (grant_rpt)
    );

    // Record one check result.
    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Driver: queue one expected grant.
    task automatic expect_grant(input int idx, input bit rp);
        exp_idx.push_back(idx);
        exp_rpt.push_back(rp);
    endtask

    // Set one master's request, level and repeat attribute.
    task automatic set_m(input int m, input bit r, input int lvl, input bit rp);
        req[m] = r;
        prio[2*m +: 2] = lvl[1:0];
        rpt[m] = rp;
    endtask

    // Synchronous reset, with the R1 idle check while it is held.
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; req = '0; prio = '0; rpt = '0; done = 1'b0;
        exp_idx.delete(); exp_rpt.delete();
        repeat (3) @(negedge clk);
        check(grant == '0 && grant_rpt == 1'b0, "R1 grant idle in reset", 32'(grant), 0);
        rst_n = 1'b1;
    endtask

    // Serve k tenures: wait for a grant, pulse done, check the release (R9).
    task automatic serve(input int k);
        for (int t = 0; t < k; t++) begin
            int w = 0;
            while (grant == '0 && w < 50) begin
                @(negedge clk);
                w++;
            end
            check(grant != '0, "R6 grant issued for pending request", 32'(grant), 1);
            done = 1'b1;
            @(negedge clk);
            done = 1'b0;
            check(grant == '0, "R9 grant cleared on done", 32'(grant), 0);
        end
    endtask

    // Monitor: each newly raised grant is compared with the queue head.
    always @(negedge clk) begin
        if (!rst_n) begin
            prev_grant = '0;
        end else begin
            if (grant != '0 && prev_grant == '0) begin
                if (exp_idx.size() == 0) begin
                    check(1'b0, "R2 unexpected grant", 32'(grant), 0);
                end else begin
                    int  ei;
                    bit  er;
                    ei = exp_idx.pop_front();
                    er = exp_rpt.pop_front();
                    check(grant == (N'(1) << ei), "R4 R5 grant order", 32'(grant), 32'(N'(1) << ei));
                    check(grant_rpt == er, "R10 repeat status", 32'(grant_rpt), 32'(er));
                end
            end
            prev_grant = grant;
        end
    end

    // Watchdog: an expired run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // R1, R4: level 0 only; lowest index first, then cyclic order.
        do_reset();
        set_m(2, 1, 0, 0); set_m(5, 1, 0, 0); set_m(7, 1, 0, 0);
        expect_grant(2, 0); expect_grant(5, 0); expect_grant(7, 0); expect_grant(2, 0);
        serve(4);
        req = '0;
        check(exp_idx.size() == 0, "R4 all expected grants seen", 32'(exp_idx.size()), 0);

        // R7, R5: 6 at level 3, 4 and 5 at level 2, 0 at level 1.
        do_reset();
        set_m(6, 1, 3, 0); set_m(4, 1, 2, 0); set_m(5, 1, 2, 0); set_m(0, 1, 1, 0);
        for (int rep = 0; rep < 2; rep++) begin
            expect_grant(6, 0); expect_grant(4, 0); expect_grant(6, 0);
            expect_grant(5, 0); expect_grant(6, 0); expect_grant(0, 0);
        end
        serve(12);
        req = '0;
        check(exp_idx.size() == 0, "R7 bandwidth pattern complete", 32'(exp_idx.size()), 0);

        // R6: no lower requests, so level 2's placeholder is passed over.
        do_reset();
        set_m(6, 1, 3, 0); set_m(4, 1, 2, 0); set_m(5, 1, 2, 0);
        expect_grant(6, 0); expect_grant(4, 0); expect_grant(6, 0);
        expect_grant(5, 0); expect_grant(6, 0); expect_grant(4, 0);
        serve(6);
        // R6: a lone top-level master gets every grant.
        req = '0;
        set_m(3, 1, 3, 0);
        expect_grant(3, 0); expect_grant(3, 0); expect_grant(3, 0);
        serve(3);
        req = '0;
        check(exp_idx.size() == 0, "R6 placeholder skipped", 32'(exp_idx.size()), 0);

        // R3, R8: the higher level wins; a level change applies at the next decision.
        do_reset();
        set_m(1, 1, 0, 0); set_m(2, 1, 2, 0);
        expect_grant(2, 0);
        serve(1);
        set_m(1, 1, 3, 0);
        expect_grant(1, 0); expect_grant(2, 0);
        serve(2);
        req = '0;
        check(exp_idx.size() == 0, "R3 R8 level order", 32'(exp_idx.size()), 0);

        // R10: the repeat attribute follows the granted master.
        do_reset();
        set_m(3, 1, 0, 1); set_m(4, 1, 0, 0);
        expect_grant(3, 1); expect_grant(4, 0); expect_grant(3, 1);
        serve(3);
        req = '0;
        check(exp_idx.size() == 0, "R10 repeat sequence", 32'(exp_idx.size()), 0);

        // R11: no request, and a stray done pulse, give no grant.
        do_reset();
        repeat (4) @(negedge clk);
        check(grant == '0, "R11 no grant without request", 32'(grant), 0);
        done = 1'b1;
        @(negedge clk);
        done = 1'b0;
        @(negedge clk);
        check(grant == '0, "R11 stray done ignored", 32'(grant), 0);

        // R9: one-cycle latency, then hold while done stays low.
        expect_grant(5, 0);
        set_m(5, 1, 0, 0);
        @(negedge clk);
        check(grant == N'(1 << 5), "R9 grant one cycle after request", 32'(grant), 32'(1 << 5));
        for (int c = 0; c < 5; c++) begin
            @(negedge clk);
            check(grant == N'(1 << 5), "R9 grant held until done", 32'(grant), 32'(1 << 5));
        end
        // R9: after the release, the next grant comes one cycle later.
        expect_grant(5, 0);
        serve(1);
        @(negedge clk);
        check(grant == N'(1 << 5), "R9 next decision one cycle after release", 32'(grant), 32'(1 << 5));
        serve(1);
        req = '0;
        check(exp_idx.size() == 0, "R9 expected grants seen", 32'(exp_idx.size()), 0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule